// File: doc/BRIEF.md
# Multi-core local interrupt router

The router gathers level-sensitive interrupt sources for a cluster of four processor cores and presents two request lines to each core: a normal interrupt line (IRQ) and a fast interrupt line (FIQ). Each core has four private timer sources and four mailbox-pending flags, which come from a separate mailbox block. A single shared interrupt and a single shared fast interrupt arrive from the peripheral interrupt controller. Per-core enable registers decide, source by source, whether an active source reaches the core's IRQ line, its FIQ line, or neither. A routing register picks which one core receives each shared input.

Nothing is latched. Each core has one 32-bit pending word per line, and the words are pure combinational functions of the current source levels and register contents. A source that drops therefore disappears from its word with no clear action. Software reaches the block through a single-cycle request port (valid, write, address, write data). Read data is registered at the request edge and is held until the next read. The access decoder sorts every address into one of six named regions: routing, timer enables, mailbox enables, IRQ pending, FIQ pending, and unmapped. A `unique case` over those regions drives both the write path and the read path.

Top module: `lirq_router`

## Requirements
- R1: After reset, the routing register and all enable registers hold zero, `reg_rdata_o` is zero, and every `core_irq_o` and `core_fiq_o` is low while no source is active.
- R2: Offset 0x40+4*c is the timer enable register of core c. Bit n enables timer source n (input `timer_src_i[4*c+n]`) onto IRQ, and bit n+4 enables it onto FIQ. The source appears at bit n of the pending word. A write keeps only data bits [7:0], and a read returns zero above bit 7.
- R3: Offset 0x50+4*c is the mailbox enable register of core c. Bit n enables mailbox flag n (input `mbox_pend_i[4*c+n]`) onto IRQ, and bit n+4 enables it onto FIQ. The flag appears at bit 4+n of the pending word. A write keeps only data bits [7:0].
- R4: An active local source whose FIQ enable is set appears only in the FIQ pending word, whatever its IRQ enable holds. An active source with neither enable set appears in neither word.
- R5: The routing register at offset 0x0C holds the IRQ target core in bits [1:0] and the FIQ target core in bits [3:2]. A write discards all other data bits, and a read returns zero above bit 3.
- R6: While `periph_irq_i` is high, bit 8 is set in the IRQ pending word of the IRQ target core and of no other core. While `periph_fiq_i` is high, bit 8 is set in the FIQ pending word of the FIQ target core and of no other core. The local enable registers do not gate bit 8.
- R7: The IRQ pending word of core c reads at 0x60+4*c and the FIQ pending word at 0x70+4*c. Bits [31:9] read zero, and writes to these offsets change nothing.
- R8: `core_irq_o[c]` is high exactly when the IRQ pending word of core c is nonzero, and `core_fiq_o[c]` is high exactly when the FIQ pending word of core c is nonzero.
- R9: An offset that is misaligned (address bits [1:0] nonzero) or outside the mapped registers reads zero, and a write to it changes no register.
- R10: A read request that is present at a rising edge loads `reg_rdata_o` at that edge with the value implied by the source levels and register contents at that edge. `reg_rdata_o` then holds its value through idle cycles and write cycles.
- R11: When a source is deasserted, its pending bit and, if no other bit remains, the core line fall without any register access and before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_src_i | input | 4*NUM_CORES | Timer source levels, core c at bits [4c+3:4c] |
| mbox_pend_i | input | 4*NUM_CORES | Mailbox-pending flags, core c at bits [4c+3:4c] |
| periph_irq_i | input | 1 | Shared peripheral interrupt level |
| periph_fiq_i | input | 1 | Shared peripheral fast interrupt level |
| reg_valid_i | input | 1 | Access request strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| core_irq_o | output | NUM_CORES | IRQ line per core |
| core_fiq_o | output | NUM_CORES | FIQ line per core |

## Verification
Two activities can land on the same edge: a source changing level and a read that captures the pending word that source feeds. The bench provokes this by raising or lowering a timer or mailbox input on the same falling edge that it presents a read of that core's pending word. The captured word must already show the new level, because the word is combinational and the read register samples it at the rising edge. A routing write issued while the shared inputs stay high is judged the same way: after that single edge, bit 8 must have moved to the new target core and must be absent from the old one.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int CTL_W       = 8;
    localparam int SRC_PER_GRP = 4;
    localparam int ROUTE_W     = 2;

    localparam int BIT_TIMER0  = 0;
    localparam int BIT_MBOX0   = 4;
    localparam int BIT_PERIPH  = 8;

    localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h0C;
    localparam logic [3:0]        BANK_TCTL  = 4'h4;
    localparam logic [3:0]        BANK_MCTL  = 4'h5;
    localparam logic [3:0]        BANK_IPEND = 4'h6;
    localparam logic [3:0]        BANK_FPEND = 4'h7;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_ROUTE,
        RG_TCTL,
        RG_MCTL,
        RG_IPEND,
        RG_FPEND
    } reg_region_e;

    function automatic reg_region_e region_of(input logic [ADDR_W-1:0] a, input int ncores);
        reg_region_e r;
        r = RG_NONE;
        if (a[1:0] == 2'b00) begin
            if (a == OFS_ROUTE) begin
                r = RG_ROUTE;
            end else if (int'(a[3:2]) < ncores) begin
                unique case (a[7:4])
                    BANK_TCTL:  r = RG_TCTL;
                    BANK_MCTL:  r = RG_MCTL;
                    BANK_IPEND: r = RG_IPEND;
                    BANK_FPEND: r = RG_FPEND;
                    default:    r = RG_NONE;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lirq_group.sv
module lirq_group #(
    parameter int N = 4
) (
    input  logic [N-1:0]   src,
    input  logic [2*N-1:0] ctl,
    output logic [N-1:0]   irq_bits,
    output logic [N-1:0]   fiq_bits
);

    for (genvar n = 0; n < N; n++) begin : g_src
        logic fiq_en;
        logic irq_en;
        assign fiq_en      = ctl[n + N];
        assign irq_en      = ctl[n];
        // fast enable wins over normal enable
        assign fiq_bits[n] = src[n] & fiq_en;
        assign irq_bits[n] = src[n] & irq_en & ~fiq_en;
    end

endmodule

// File: rtl/lirq_steer.sv
module lirq_steer
    import lirq_pkg::*;
#(
    parameter int CORE_ID = 0
) (
    input  logic [SRC_PER_GRP-1:0] timer_src,
    input  logic [SRC_PER_GRP-1:0] mbox_src,
    input  logic [CTL_W-1:0]       tctl,
    input  logic [CTL_W-1:0]       mctl,
    input  logic                   periph_irq,
    input  logic                   periph_fiq,
    input  logic [ROUTE_W-1:0]     route_irq,
    input  logic [ROUTE_W-1:0]     route_fiq,
    output logic [DATA_W-1:0]      irq_word,
    output logic [DATA_W-1:0]      fiq_word
);

    localparam logic [ROUTE_W-1:0] MY_ID = ROUTE_W'(CORE_ID);

    logic [SRC_PER_GRP-1:0] tm_irq, tm_fiq, mb_irq, mb_fiq;
    logic                   sh_irq, sh_fiq;

    lirq_group #(.N(SRC_PER_GRP)) u_timer (
        .src      (timer_src),
        .ctl      (tctl),
        .irq_bits (tm_irq),
        .fiq_bits (tm_fiq)
    );

    lirq_group #(.N(SRC_PER_GRP)) u_mbox (
        .src      (mbox_src),
        .ctl      (mctl),
        .irq_bits (mb_irq),
        .fiq_bits (mb_fiq)
    );

    assign sh_irq = periph_irq & (route_irq == MY_ID);
    assign sh_fiq = periph_fiq & (route_fiq == MY_ID);

    always_comb begin
        irq_word = '0;
        fiq_word = '0;
        irq_word[BIT_TIMER0 +: SRC_PER_GRP] = tm_irq;
        fiq_word[BIT_TIMER0 +: SRC_PER_GRP] = tm_fiq;
        irq_word[BIT_MBOX0  +: SRC_PER_GRP] = mb_irq;
        fiq_word[BIT_MBOX0  +: SRC_PER_GRP] = mb_fiq;
        irq_word[BIT_PERIPH]                = sh_irq;
        fiq_word[BIT_PERIPH]                = sh_fiq;
    end

endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
    import lirq_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_valid_i,
    input  logic                              reg_write_i,
    input  logic [ADDR_W-1:0]                 reg_addr_i,
    input  logic [DATA_W-1:0]                 reg_wdata_i,
    input  logic [NUM_CORES-1:0][DATA_W-1:0]  irq_word,
    input  logic [NUM_CORES-1:0][DATA_W-1:0]  fiq_word,
    output logic [DATA_W-1:0]                 reg_rdata_o,
    output logic [ROUTE_W-1:0]                route_irq,
    output logic [ROUTE_W-1:0]                route_fiq,
    output logic [NUM_CORES-1:0][CTL_W-1:0]   tctl,
    output logic [NUM_CORES-1:0][CTL_W-1:0]   mctl
);

    localparam int SLOT_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    reg_region_e         region;
    logic [SLOT_W-1:0]   slot;
    logic [DATA_W-1:0]   rd_next;
    logic                unused_wdata_hi;

    assign region          = region_of(reg_addr_i, NUM_CORES);
    assign slot            = reg_addr_i[2 +: SLOT_W];
    assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:CTL_W];

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_irq <= '0;
            route_fiq <= '0;
            tctl      <= '0;
            mctl      <= '0;
        end else if (reg_valid_i && reg_write_i) begin
            unique case (region)
                RG_ROUTE: begin
                    route_irq <= reg_wdata_i[0 +: ROUTE_W];
                    route_fiq <= reg_wdata_i[ROUTE_W +: ROUTE_W];
                end
                RG_TCTL:  tctl[slot] <= reg_wdata_i[CTL_W-1:0];
                RG_MCTL:  mctl[slot] <= reg_wdata_i[CTL_W-1:0];
                default:  ;
            endcase
        end
    end

    // read selection
    always_comb begin
        rd_next = '0;
        unique case (region)
            RG_ROUTE: rd_next = DATA_W'({route_fiq, route_irq});
            RG_TCTL:  rd_next = DATA_W'(tctl[slot]);
            RG_MCTL:  rd_next = DATA_W'(mctl[slot]);
            RG_IPEND: rd_next = irq_word[slot];
            RG_FPEND: rd_next = fiq_word[slot];
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata_o <= '0;
        end else if (reg_valid_i && !reg_write_i) begin
            reg_rdata_o <= rd_next;
        end
    end

endmodule

// File: rtl/lirq_router.sv
module lirq_router
    import lirq_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [SRC_PER_GRP*NUM_CORES-1:0] timer_src_i,
    input  logic [SRC_PER_GRP*NUM_CORES-1:0] mbox_pend_i,
    input  logic                            periph_irq_i,
    input  logic                            periph_fiq_i,
    input  logic                            reg_valid_i,
    input  logic                            reg_write_i,
    input  logic [ADDR_W-1:0]               reg_addr_i,
    input  logic [DATA_W-1:0]               reg_wdata_i,
    output logic [DATA_W-1:0]               reg_rdata_o,
    output logic [NUM_CORES-1:0]            core_irq_o,
    output logic [NUM_CORES-1:0]            core_fiq_o
);

    logic [ROUTE_W-1:0]               route_irq, route_fiq;
    logic [NUM_CORES-1:0][CTL_W-1:0]  tctl, mctl;
    logic [NUM_CORES-1:0][DATA_W-1:0] irq_word, fiq_word;

    lirq_regs #(.NUM_CORES(NUM_CORES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_valid_i (reg_valid_i),
        .reg_write_i (reg_write_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .irq_word    (irq_word),
        .fiq_word    (fiq_word),
        .reg_rdata_o (reg_rdata_o),
        .route_irq   (route_irq),
        .route_fiq   (route_fiq),
        .tctl        (tctl),
        .mctl        (mctl)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        lirq_steer #(.CORE_ID(c)) u_steer (
            .timer_src  (timer_src_i[c*SRC_PER_GRP +: SRC_PER_GRP]),
            .mbox_src   (mbox_pend_i[c*SRC_PER_GRP +: SRC_PER_GRP]),
            .tctl       (tctl[c]),
            .mctl       (mctl[c]),
            .periph_irq (periph_irq_i),
            .periph_fiq (periph_fiq_i),
            .route_irq  (route_irq),
            .route_fiq  (route_fiq),
            .irq_word   (irq_word[c]),
            .fiq_word   (fiq_word[c])
        );
        assign core_irq_o[c] = |irq_word[c];
        assign core_fiq_o[c] = |fiq_word[c];
    end

endmodule

// File: rtl/lirq_router_chk.sv
module lirq_router_chk
    import lirq_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SRC_PER_GRP*NUM_CORES-1:0] timer_src_i,
    input  logic [SRC_PER_GRP*NUM_CORES-1:0] mbox_pend_i,
    input  logic                             periph_irq_i,
    input  logic                             periph_fiq_i,
    input  logic                             reg_valid_i,
    input  logic                             reg_write_i,
    input  logic [ADDR_W-1:0]                reg_addr_i,
    input  logic [DATA_W-1:0]                reg_rdata_o,
    input  logic [NUM_CORES-1:0]             core_irq_o,
    input  logic [NUM_CORES-1:0]             core_fiq_o,
    input  logic [NUM_CORES-1:0][DATA_W-1:0] irq_word,
    input  logic [NUM_CORES-1:0][DATA_W-1:0] fiq_word
);

    logic [NUM_CORES-1:0] sh_irq_bits, sh_fiq_bits;
    logic                 is_read, quiet;

    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            sh_irq_bits[c] = irq_word[c][BIT_PERIPH];
            sh_fiq_bits[c] = fiq_word[c][BIT_PERIPH];
        end
    end

    assign is_read = reg_valid_i && !reg_write_i;
    assign quiet   = (timer_src_i == '0) && (mbox_pend_i == '0) && !periph_irq_i && !periph_fiq_i;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        // R4: a local source never shows in both words
        p_fiq_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_word[c][BIT_PERIPH-1:0] & fiq_word[c][BIT_PERIPH-1:0]) == '0);
        // R7: reserved bits stay clear
        p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_word[c][DATA_W-1:BIT_PERIPH+1] == '0) && (fiq_word[c][DATA_W-1:BIT_PERIPH+1] == '0));
    end

    p_periph_irq_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_irq_i |-> ($countones(sh_irq_bits) == 1));
    p_periph_irq_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_irq_i |-> (sh_irq_bits == '0));
    p_periph_fiq_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_fiq_i |-> ($countones(sh_fiq_bits) == 1));
    p_periph_fiq_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_fiq_i |-> (sh_fiq_bits == '0));
    p_quiet_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> (core_irq_o == '0) && (core_fiq_o == '0));
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && (region_of(reg_addr_i, NUM_CORES) == RG_NONE)) |=> (reg_rdata_o == '0));
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> $stable(reg_rdata_o));

endmodule

bind lirq_router lirq_router_chk #(.NUM_CORES(NUM_CORES)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .timer_src_i  (timer_src_i),
    .mbox_pend_i  (mbox_pend_i),
    .periph_irq_i (periph_irq_i),
    .periph_fiq_i (periph_fiq_i),
    .reg_valid_i  (reg_valid_i),
    .reg_write_i  (reg_write_i),
    .reg_addr_i   (reg_addr_i),
    .reg_rdata_o  (reg_rdata_o),
    .core_irq_o   (core_irq_o),
    .core_fiq_o   (core_fiq_o),
    .irq_word     (irq_word),
    .fiq_word     (fiq_word)
);

// File: tb/test_lirq_router.sv
module test_lirq_router;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   timer_src = '0;
    logic [15:0]   mbox_pend = '0;
    logic          pirq = 1'b0, pfiq = 1'b0;
    logic          reg_valid = 1'b0, reg_write = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   rdata;
    logic [NC-1:0] core_irq, core_fiq;

    logic [7:0]    tctl_m [NC];
    logic [7:0]    mctl_m [NC];
    logic [1:0]    rirq_m = '0, rfiq_m = '0;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lirq_router #(.NUM_CORES(NC)) i_lirq_router (
        .clk          (clk),
        .rst_n        (rst_n),
        .timer_src_i  (timer_src),
        .mbox_pend_i  (mbox_pend),
        .periph_irq_i (pirq),
        .periph_fiq_i (pfiq),
        .reg_valid_i  (reg_valid),
        .reg_write_i  (reg_write),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (rdata),
        .core_irq_o   (core_irq),
        .core_fiq_o   (core_fiq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int c, input bit fast);
        logic [31:0] w;
        w = '0;
        for (int s = 0; s < 4; s++) begin
            if (timer_src[4*c+s]) begin
                if (tctl_m[c][s+4]) w[s] = fast;
                else if (tctl_m[c][s]) w[s] = !fast;
            end
            if (mbox_pend[4*c+s]) begin
                if (mctl_m[c][s+4]) w[4+s] = fast;
                else if (mctl_m[c][s]) w[4+s] = !fast;
            end
        end
        if (!fast && pirq && (int'(rirq_m) == c)) w[8] = 1'b1;
        if (fast && pfiq && (int'(rfiq_m) == c)) w[8] = 1'b1;
        return w;
    endfunction

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic check_lines(input string tag);
        for (int k = 0; k < NC; k++) begin
            chk({tag, " R8 irq line"}, 32'(core_irq[k]), 32'(exp_word(k, 0) != 0));
            chk({tag, " R8 fiq line"}, 32'(core_fiq[k]), 32'(exp_word(k, 1) != 0));
        end
    endtask

    task automatic check_words(input int c, input string tag);
        logic [31:0] d;
        rd(8'h60 + 8'(4*c), d);
        chk({tag, " R7 irq word"}, d, exp_word(c, 0));
        rd(8'h70 + 8'(4*c), d);
        chk({tag, " R7 fiq word"}, d, exp_word(c, 1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] lfsr;
        for (int c = 0; c < NC; c++) begin tctl_m[c] = '0; mctl_m[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata after reset", rdata, 32'h0);
        chk("R1 irq lines", 32'(core_irq), 32'h0);
        chk("R1 fiq lines", 32'(core_fiq), 32'h0);
        rd(8'h0C, d); chk("R1 route reset", d, 32'h0);
        for (int c = 0; c < NC; c++) begin
            rd(8'h40 + 8'(4*c), d); chk("R1 timer enable reset", d, 32'h0);
            rd(8'h50 + 8'(4*c), d); chk("R1 mailbox enable reset", d, 32'h0);
        end

        // R2/R3 width of control registers
        wr(8'h44, 32'hABCD_1234); rd(8'h44, d); chk("R2 timer enable low byte", d, 32'h34);
        wr(8'h58, 32'hFFFF_FF5A); rd(8'h58, d); chk("R3 mailbox enable low byte", d, 32'h5A);
        wr(8'h44, 32'h0); wr(8'h58, 32'h0);

        // exhaustive local sweep: core x source x enable mode
        for (int c = 0; c < NC; c++) begin
            for (int s = 0; s < 8; s++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [7:0] v;
                    string tag;
                    v = '0;
                    v[s % 4]     = m[0];
                    v[s % 4 + 4] = m[1];
                    tag = (m == 3 || m == 0) ? "R4" : ((s < 4) ? "R2" : "R3");
                    if (s < 4) begin
                        wr(8'h40 + 8'(4*c), 32'(v)); tctl_m[c] = v;
                    end else begin
                        wr(8'h50 + 8'(4*c), 32'(v)); mctl_m[c] = v;
                    end
                    @(negedge clk);
                    if (s < 4) timer_src[4*c+s] = 1'b1; else mbox_pend[4*c+s-4] = 1'b1;
                    @(negedge clk);
                    check_lines(tag);
                    check_words(c, tag);
                    // R11 drop with no register action
                    @(negedge clk);
                    if (s < 4) timer_src[4*c+s] = 1'b0; else mbox_pend[4*c+s-4] = 1'b0;
                    #1;
                    check_lines("R11 drop");
                    tctl_m[c] = '0; mctl_m[c] = '0;
                    wr(8'h40 + 8'(4*c), 32'h0);
                    wr(8'h50 + 8'(4*c), 32'h0);
                end
            end
        end

        // R5 route register width
        wr(8'h0C, 32'hFFFF_FFF6); rd(8'h0C, d); chk("R5 route fields", d, 32'h6);
        wr(8'h0C, 32'h0);

        // R6 routing sweep with local enables fully set (bit 8 not gated)
        for (int c = 0; c < NC; c++) begin
            tctl_m[c] = 8'hFF; wr(8'h40 + 8'(4*c), 32'hFF);
        end
        for (int ri = 0; ri < 4; ri++) begin
            for (int rf = 0; rf < 4; rf++) begin
                for (int pat = 0; pat < 4; pat++) begin
                    rirq_m = 2'(ri); rfiq_m = 2'(rf);
                    wr(8'h0C, 32'(rf * 4 + ri));
                    @(negedge clk);
                    pirq = pat[0]; pfiq = pat[1];
                    @(negedge clk);
                    check_lines("R6 route");
                    for (int c = 0; c < NC; c++) check_words(c, "R6 route");
                end
            end
        end

        // R6/R10 route change on the edge while shared inputs held high
        pirq = 1'b1; pfiq = 1'b1;
        rirq_m = 2'd1; rfiq_m = 2'd2; wr(8'h0C, 32'h9);
        rd(8'h61, d); chk("R9 misaligned read", d, 32'h0);
        check_words(1, "R6 after reroute");
        check_words(3, "R6 old target clear");
        pirq = 1'b0; pfiq = 1'b0;
        for (int c = 0; c < NC; c++) begin
            tctl_m[c] = '0; wr(8'h40 + 8'(4*c), 32'h0);
        end

        // R7 writes to pending words ignored
        tctl_m[2] = 8'h01; wr(8'h48, 32'h01);
        @(negedge clk); timer_src[8] = 1'b1;
        wr(8'h68, 32'h0); wr(8'h78, 32'hFFFF_FFFF);
        check_words(2, "R7 write ignored");

        // R9 unmapped offsets
        begin
            logic [7:0] bad [6] = '{8'h00, 8'h10, 8'h41, 8'h80, 8'hC0, 8'hFC};
            foreach (bad[i]) begin
                rd(bad[i], d); chk("R9 unmapped read", d, 32'h0);
                wr(bad[i], 32'hFFFF_FFFF);
            end
            rd(8'h40, d); chk("R9 write no effect t0", d, 32'h0);
            rd(8'h48, d); chk("R9 write no effect t2", d, 32'h01);
            rd(8'h0C, d); chk("R9 write no effect route", d, 32'h9);
        end

        // R10 hold through idle and write cycles
        rd(8'h48, d);
        repeat (3) @(negedge clk);
        chk("R10 hold idle", rdata, 32'h01);
        wr(8'h4C, 32'h0);
        chk("R10 hold write", rdata, 32'h01);

        // R10 source change on the same edge as the read
        @(negedge clk);
        timer_src[8] = 1'b0;
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 8'h68;
        @(negedge clk);
        reg_valid = 1'b0;
        chk("R10 same-edge drop", rdata, 32'h0);
        @(negedge clk);
        timer_src[8] = 1'b1;
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 8'h68;
        @(negedge clk);
        reg_valid = 1'b0;
        chk("R10 same-edge rise", rdata, 32'h1);

        // mixed patterns from an LFSR
        lfsr = 32'hACE1_1234;
        for (int it = 0; it < 48; it++) begin
            for (int c = 0; c < NC; c++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                tctl_m[c] = lfsr[7:0]; mctl_m[c] = lfsr[15:8];
                wr(8'h40 + 8'(4*c), {16'hDEAD, lfsr[15:0]});
                wr(8'h50 + 8'(4*c), {24'h0, lfsr[15:8]});
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rirq_m = lfsr[1:0]; rfiq_m = lfsr[3:2];
            wr(8'h0C, 32'(lfsr[3:0]));
            @(negedge clk);
            timer_src = lfsr[19:4]; mbox_pend = {lfsr[27:20], lfsr[11:4]};
            pirq = lfsr[28]; pfiq = lfsr[29];
            @(negedge clk);
            check_lines("R4 mixed");
            check_words(it % NC, "R4 mixed");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule